// File: doc/BRIEF.md
# Wake Event and PME Output Controller

This block gathers wake events for a network interface and turns them into power-management signals. Two event pulses feed it: a magic-packet match and a detected link change from the PHY polling logic. Each event latches into a sticky status flag that software later clears by writing a one. From those flags the block drives a PME request and a remote-wake pin. The pin's active level, its push-pull or open-drain drive, and its gating by power-good are all selectable.

Link-change events are only recorded when link-change wake mode is on. That mode comes from two sources: a level input held by software logic, and an internal mode bit that hardware reset clears. An override input lets PME assert while PME enable is low. The block also times a PHY reset output. That output is active during hardware reset and for a fixed number of cycles after reset is released, and its active level is selectable.

Top module: `wake_pme_ctrl`

## Requirements
- R1: A `magic_hit` pulse sets `magic_sts` at the next clock edge. The flag stays set until a `clr_magic` strobe. If a set and a clear arrive in the same cycle, the set wins.
- R2: A `link_chg` pulse sets `link_sts` only when `lc_mode_sw` is 1 or the internal reset-cleared mode bit is 1. Otherwise the pulse is ignored. A `clr_link` strobe clears `link_sts`.
- R3: The reset-cleared mode bit is loaded from `mode_wdata` when `mode_wr` is high. Hardware reset `rst` clears it. `lc_mode_sw` is an input and reset does not touch it.
- R4: Without override, `pme_req` is 1 exactly when `pme_en` is 1 and at least one status flag is set. It is registered, so it follows the status flags one cycle later.
- R5: When `pme_ovr` is 1 and a status flag is set, `pme_req` asserts whatever the value of `pme_en`.
- R6: The wake pin asserts when either status flag is set. With `wake_pol`=1 the pin idles high and asserts low. With `wake_pol`=0 it idles low and asserts high. With `wake_pp`=1 (push-pull), `wake_oe`=1 and `wake_out` carries the level. The pin outputs are registered one cycle after the status flags.
- R7: With `wake_pp`=0 (open drain), `wake_out` is always 0. `wake_oe` is 1 only when the wanted level is low, and the pin floats otherwise.
- R8: When `gate_en`=1 and `pwr_good`=0, `wake_oe` is 0 one cycle later, regardless of the status flags.
- R9: `phy_rst_pin` is active during `rst` and for exactly `PHY_RST_CYCLES` cycles after `rst` is released. The active level is low when `phy_rst_pol`=1 and high when it is 0.
- R10: After reset, `magic_sts`, `link_sts`, `pme_req`, `wake_out` and `wake_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| pwr_good | input | 1 | Power-good level |
| pme_en | input | 1 | PME enable |
| pme_ovr | input | 1 | PME override |
| lc_mode_sw | input | 1 | Software link-change mode (not reset here) |
| mode_wr | input | 1 | Write strobe for reset-cleared link-change mode bit |
| mode_wdata | input | 1 | Value written to reset-cleared mode bit |
| magic_hit | input | 1 | Magic-packet match pulse |
| link_chg | input | 1 | Link-change detect pulse |
| clr_magic | input | 1 | Write-one-to-clear strobe for magic flag |
| clr_link | input | 1 | Write-one-to-clear strobe for link flag |
| wake_pp | input | 1 | 1 = push-pull, 0 = open drain |
| gate_en | input | 1 | Float wake pin while power-good is low |
| wake_pol | input | 1 | 1 = wake pin active low |
| phy_rst_pol | input | 1 | 1 = PHY reset active low |
| magic_sts | output | 1 | Sticky magic-match flag |
| link_sts | output | 1 | Sticky link-change flag |
| pme_req | output | 1 | PME request |
| wake_out | output | 1 | Wake pin data value |
| wake_oe | output | 1 | Wake pin output enable |
| phy_rst_pin | output | 1 | PHY reset pin level |

## Verification
The assertions check these rules on every cycle:
- the one-cycle set of each status flag;
- PME asserting under override;
- PME never asserting without a set flag;
- open-drain `wake_out` staying low;
- the gating rule;
- the PHY reset level right after reset.

Other behaviours only the bench scenarios can show. These are the exact pin level and enable for each polarity and drive mode, the ignored link pulse when both mode sources are off, and hardware reset clearing the internal mode bit while the software mode input still works. The bench scenarios also measure the length of the post-reset PHY pulse for both polarities.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef struct packed {
    logic out;
    logic oe;
  } pin_drv_t;

  // Wanted pin level for a given assert state and polarity.
  function automatic logic wanted_level(input logic asserted, input logic pol);
    return asserted ? ~pol : pol;
  endfunction
endpackage

// File: rtl/wake_status.sv
module wake_status (
  input  logic clk,
  input  logic rst,
  input  logic lc_mode_sw,
  input  logic mode_wr,
  input  logic mode_wdata,
  input  logic magic_hit,
  input  logic link_chg,
  input  logic clr_magic,
  input  logic clr_link,
  output logic magic_sts,
  output logic link_sts
);
  logic lcm_hw;
  logic link_en;

  assign link_en = lc_mode_sw | lcm_hw;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcm_hw    <= 1'b0;
      magic_sts <= 1'b0;
      link_sts  <= 1'b0;
    end else begin
      if (mode_wr) lcm_hw <= mode_wdata;
      if (magic_hit)      magic_sts <= 1'b1;
      else if (clr_magic) magic_sts <= 1'b0;
      if (link_chg && link_en) link_sts <= 1'b1;
      else if (clr_link)       link_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_pin_drv.sv
module wake_pin_drv
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic magic_sts,
  input  logic link_sts,
  input  logic pme_en,
  input  logic pme_ovr,
  input  logic pwr_good,
  input  logic wake_pp,
  input  logic gate_en,
  input  logic wake_pol,
  output logic pme_req,
  output logic wake_out,
  output logic wake_oe
);
  logic     any_sts;
  logic     level;
  pin_drv_t drv_nxt;

  assign any_sts = magic_sts | link_sts;
  assign level   = wanted_level(any_sts, wake_pol);

  always_comb begin
    if (gate_en && !pwr_good) begin
      drv_nxt.out = wake_pp ? level : 1'b0;
      drv_nxt.oe  = 1'b0;
    end else if (wake_pp) begin
      drv_nxt.out = level;
      drv_nxt.oe  = 1'b1;
    end else begin
      drv_nxt.out = 1'b0;
      drv_nxt.oe  = ~level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_req  <= 1'b0;
      wake_out <= 1'b0;
      wake_oe  <= 1'b0;
    end else begin
      pme_req  <= any_sts & (pme_en | pme_ovr);
      wake_out <= drv_nxt.out;
      wake_oe  <= drv_nxt.oe;
    end
  end
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pol,
  output logic pin
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= LOAD;
      pin <= ~pol;
    end else begin
      pin <= (cnt != '0) ^ pol;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl #(
  parameter int unsigned PHY_RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic pme_en,
  input  logic pme_ovr,
  input  logic lc_mode_sw,
  input  logic mode_wr,
  input  logic mode_wdata,
  input  logic magic_hit,
  input  logic link_chg,
  input  logic clr_magic,
  input  logic clr_link,
  input  logic wake_pp,
  input  logic gate_en,
  input  logic wake_pol,
  input  logic phy_rst_pol,
  output logic magic_sts,
  output logic link_sts,
  output logic pme_req,
  output logic wake_out,
  output logic wake_oe,
  output logic phy_rst_pin
);
  wake_status u_sts (
    .clk(clk), .rst(rst), .lc_mode_sw(lc_mode_sw), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .magic_hit(magic_hit), .link_chg(link_chg),
    .clr_magic(clr_magic), .clr_link(clr_link),
    .magic_sts(magic_sts), .link_sts(link_sts)
  );

  wake_pin_drv u_drv (
    .clk(clk), .rst(rst), .magic_sts(magic_sts), .link_sts(link_sts),
    .pme_en(pme_en), .pme_ovr(pme_ovr), .pwr_good(pwr_good),
    .wake_pp(wake_pp), .gate_en(gate_en), .wake_pol(wake_pol),
    .pme_req(pme_req), .wake_out(wake_out), .wake_oe(wake_oe)
  );

  phy_rst_seq #(.CYCLES(PHY_RST_CYCLES)) u_phy (
    .clk(clk), .rst(rst), .pol(phy_rst_pol), .pin(phy_rst_pin)
  );
endmodule

// File: rtl/wake_pme_ctrl_chk.sv
module wake_pme_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic pme_ovr,
  input logic lc_mode_sw,
  input logic magic_hit,
  input logic link_chg,
  input logic wake_pp,
  input logic gate_en,
  input logic phy_rst_pol,
  input logic magic_sts,
  input logic link_sts,
  input logic pme_req,
  input logic wake_out,
  input logic wake_oe,
  input logic phy_rst_pin
);
  p_magic_set_r1: assert property (@(posedge clk) disable iff (rst)
    magic_hit |=> magic_sts);

  p_link_set_r2: assert property (@(posedge clk) disable iff (rst)
    (link_chg && lc_mode_sw) |=> link_sts);

  p_pme_src_r4: assert property (@(posedge clk) disable iff (rst)
    pme_req |-> $past(magic_sts || link_sts));

  p_override_r5: assert property (@(posedge clk) disable iff (rst)
    (pme_ovr && (magic_sts || link_sts)) |=> pme_req);

  p_od_low_r7: assert property (@(posedge clk) disable iff (rst)
    !wake_pp |=> !wake_out);

  p_gate_float_r8: assert property (@(posedge clk) disable iff (rst)
    (gate_en && !pwr_good) |=> !wake_oe);

  p_phy_active_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phy_rst_pin == !$past(phy_rst_pol)));
endmodule

bind wake_pme_ctrl wake_pme_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .pme_ovr(pme_ovr),
  .lc_mode_sw(lc_mode_sw), .magic_hit(magic_hit), .link_chg(link_chg),
  .wake_pp(wake_pp), .gate_en(gate_en), .phy_rst_pol(phy_rst_pol),
  .magic_sts(magic_sts), .link_sts(link_sts), .pme_req(pme_req),
  .wake_out(wake_out), .wake_oe(wake_oe), .phy_rst_pin(phy_rst_pin)
);

// File: tb/test_wake_pme_ctrl.sv
module test_wake_pme_ctrl;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b1, pme_en = 1'b0, pme_ovr = 1'b0, lc_mode_sw = 1'b0;
  logic mode_wr = 1'b0, mode_wdata = 1'b0, magic_hit = 1'b0, link_chg = 1'b0;
  logic clr_magic = 1'b0, clr_link = 1'b0, wake_pp = 1'b1, gate_en = 1'b0;
  logic wake_pol = 1'b0, phy_rst_pol = 1'b0;
  logic magic_sts, link_sts, pme_req, wake_out, wake_oe, phy_rst_pin;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wake_pme_ctrl #(.PHY_RST_CYCLES(N)) i_wake_pme_ctrl (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic clear_all();
    clr_magic = 1'b1; clr_link = 1'b1; tick();
    clr_magic = 1'b0; clr_link = 1'b0; tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 magic_sts", magic_sts, 1'b0);
    chk("R10 link_sts", link_sts, 1'b0);
    chk("R10 pme_req", pme_req, 1'b0);
    chk("R10 wake_out", wake_out, 1'b0);
    chk("R10 wake_oe", wake_oe, 1'b0);
  endtask

  task automatic t_magic();
    magic_hit = 1'b1; tick(); magic_hit = 1'b0;
    chk("R1 set", magic_sts, 1'b1);
    tick(); tick();
    chk("R1 sticky", magic_sts, 1'b1);
    magic_hit = 1'b1; clr_magic = 1'b1; tick();
    magic_hit = 1'b0; clr_magic = 1'b0;
    chk("R1 set beats clear", magic_sts, 1'b1);
    clr_magic = 1'b1; tick(); clr_magic = 1'b0;
    chk("R1 w1c", magic_sts, 1'b0);
    tick();
  endtask

  task automatic t_link_mode();
    lc_mode_sw = 1'b0;
    link_chg = 1'b1; tick(); link_chg = 1'b0;
    chk("R2 ignored no mode", link_sts, 1'b0);
    lc_mode_sw = 1'b1;
    link_chg = 1'b1; tick(); link_chg = 1'b0;
    chk("R2 set sw mode", link_sts, 1'b1);
    clr_link = 1'b1; tick(); clr_link = 1'b0;
    chk("R2 w1c", link_sts, 1'b0);
    lc_mode_sw = 1'b0;
  endtask

  task automatic t_hw_mode();
    mode_wdata = 1'b1; mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    link_chg = 1'b1; tick(); link_chg = 1'b0;
    chk("R3 hw mode enables", link_sts, 1'b1);
    do_reset();
    link_chg = 1'b1; tick(); link_chg = 1'b0;
    chk("R3 reset cleared hw mode", link_sts, 1'b0);
    lc_mode_sw = 1'b1;
    link_chg = 1'b1; tick(); link_chg = 1'b0;
    chk("R3 sw mode survives", link_sts, 1'b1);
    lc_mode_sw = 1'b0;
    clear_all();
  endtask

  task automatic t_pme();
    pme_en = 1'b0; pme_ovr = 1'b0;
    magic_hit = 1'b1; tick(); magic_hit = 1'b0; tick();
    chk("R4 disabled", pme_req, 1'b0);
    pme_en = 1'b1; tick();
    chk("R4 enabled", pme_req, 1'b1);
    clear_all();
    chk("R4 no source", pme_req, 1'b0);
    pme_en = 1'b0;
  endtask

  task automatic t_override();
    pme_ovr = 1'b1; pme_en = 1'b0;
    tick();
    chk("R5 no source", pme_req, 1'b0);
    lc_mode_sw = 1'b1;
    link_chg = 1'b1; tick(); link_chg = 1'b0; tick();
    chk("R5 override", pme_req, 1'b1);
    lc_mode_sw = 1'b0; pme_ovr = 1'b0;
    clear_all();
  endtask

  task automatic t_pushpull();
    wake_pp = 1'b1; gate_en = 1'b0;
    for (int p = 0; p < 2; p++) begin
      wake_pol = p[0];
      tick(); tick();
      chk("R6 idle out", wake_out, p[0]);
      chk("R6 idle oe", wake_oe, 1'b1);
      magic_hit = 1'b1; tick(); magic_hit = 1'b0; tick();
      chk("R6 assert out", wake_out, ~p[0]);
      chk("R6 assert oe", wake_oe, 1'b1);
      clear_all();
    end
  endtask

  task automatic t_opendrain();
    wake_pp = 1'b0; gate_en = 1'b0;
    for (int p = 0; p < 2; p++) begin
      wake_pol = p[0];
      tick(); tick();
      chk("R7 idle out", wake_out, 1'b0);
      chk("R7 idle oe", wake_oe, p[0] == 1'b0);
      magic_hit = 1'b1; tick(); magic_hit = 1'b0; tick();
      chk("R7 assert out", wake_out, 1'b0);
      chk("R7 assert oe", wake_oe, p[0] == 1'b1);
      clear_all();
    end
    wake_pp = 1'b1;
  endtask

  task automatic t_gate();
    wake_pp = 1'b1; wake_pol = 1'b0; gate_en = 1'b1; pwr_good = 1'b0;
    magic_hit = 1'b1; tick(); magic_hit = 1'b0; tick();
    chk("R8 gated float", wake_oe, 1'b0);
    pwr_good = 1'b1; tick();
    chk("R8 power good drives", wake_oe, 1'b1);
    chk("R8 power good level", wake_out, 1'b1);
    gate_en = 1'b0; pwr_good = 1'b0; tick();
    chk("R8 no gate drives", wake_oe, 1'b1);
    pwr_good = 1'b1;
    clear_all();
  endtask

  task automatic t_phy_rst();
    for (int p = 0; p < 2; p++) begin
      int act_cnt = 0;
      phy_rst_pol = p[0];
      rst = 1'b1; tick(); tick();
      chk("R9 active in reset", phy_rst_pin, ~p[0]);
      rst = 1'b0;
      for (int k = 0; k < 3 * N; k++) begin
        tick();
        if (phy_rst_pin == ~p[0]) act_cnt++;
      end
      checks++;
      if (act_cnt != N) begin
        errors++;
        $display("FAIL R9 pulse length actual=%0d expected=%0d", act_cnt, N);
      end
      chk("R9 inactive after", phy_rst_pin, p[0]);
    end
    phy_rst_pol = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_magic();
    t_link_mode();
    t_hw_mode();
    t_pme();
    t_override();
    t_pushpull();
    t_opendrain();
    t_gate();
    t_phy_rst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule